// File: doc/BRIEF.md
# Training Pattern Register Readout

This block is the device-side store of known bit patterns used while a host trains its data links. Four 8-bit pattern registers come out of reset holding fixed patterns. Software on the host side may overwrite them. Each read request returns one burst of 8 unit intervals (UIs) across 8 data lanes. The bits are laid out in one of three ways: serial, parallel or staggered.

Register access is gated by an enable flag. The flag can only be turned on by a mode command that follows a precharge-all. While the flag is clear, writes do not touch the registers and reads return nothing. In staggered form each lane draws from a different register. The assignment rotates by one register on every staggered read, so four reads in a row visit every lane/register pairing.

The burst is delivered one clock after the read request as a single 64-bit word with a valid flag. UI n, lane i sits at bit `n*8+i`.

Top module: `mpr_train_readout`

## Requirements
- R1: After reset the registers hold 8'h55, 8'h33, 8'h0F and 8'h00 (register 0, 1, 2, 3). After reset the enable flag is clear, the readout form is serial, the rotation index is 0 and `burst_valid_o` is low.
- R2: A mode command (`mode_cmd_i`) with `mode_on_i`=1 sets the enable flag only if a precharge-all (`pre_all_i`) arrived after the previous mode command. Without that precharge-all, it leaves the flag unchanged. A mode command with `mode_on_i`=0 always clears the flag. `mpr_active_o` shows the new value from the cycle after the command.
- R3: While the flag is set, a write stores `wr_data_i` into the register selected by `wr_sel_i`. A read issued on the next cycle or later returns the new value.
- R4: While the flag is clear, writes leave every register unchanged. A read then gives `burst_valid_o`=0 and an all-zero `burst_o`.
- R5: Readout form code 2'b00 is serial. Every lane in UI n carries bit (7-n) of the register selected by `rd_sel_i`.
- R6: Readout form code 2'b01 is parallel. In every UI, lane i carries bit i of the selected register.
- R7: Readout form code 2'b10 is staggered. In UI n, lane i carries bit (7-n) of register ((i mod 4) + k) mod 4, where k is the rotation index. `rd_sel_i` is ignored in this form.
- R8: The rotation index k returns to 0 on every mode command. It advances by one after each staggered read made while the flag is set, and wraps from 3 to 0.
- R9: Readout form code 2'b11 is reserved and behaves exactly as serial.
- R10: `burst_valid_o` is high for exactly the one cycle after a read accepted with the flag set. Whenever it is low, `burst_o` is all zeros. The readout form is latched from `mode_fmt_i` on every mode command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pre_all_i | input | 1 | Precharge-all seen, arms the enable path |
| mode_cmd_i | input | 1 | Mode command strobe |
| mode_on_i | input | 1 | Mode command: 1 requests register access, 0 leaves it |
| mode_fmt_i | input | 2 | Mode command: readout form code |
| wr_i | input | 1 | Pattern register write strobe |
| wr_sel_i | input | 2 | Register targeted by the write |
| wr_data_i | input | 8 | Value to store |
| rd_i | input | 1 | Read request strobe |
| rd_sel_i | input | 2 | Register read in serial and parallel forms |
| mpr_active_o | output | 1 | Enable flag |
| burst_valid_o | output | 1 | Burst on `burst_o` is valid |
| burst_o | output | 64 | Burst, UI n lane i at bit n*8+i |

## Verification
The bench targets the rotation of the staggered form across five consecutive reads. A counter that fails to wrap or advance would repeat or skip a lane assignment. It also checks that a new mode command puts the rotation back to zero, so a stale index would show as a shifted pattern. The bench tries to enable the path without a precharge-all first, and writes while the path is closed. A design that ignored the gating would either turn on or corrupt the reset patterns that later reads expose. The reserved form code must read back as serial, and a direct write followed at once by a read must return the fresh value.

// File: rtl/mpr_train_pkg.sv
package mpr_train_pkg;

    localparam int MPR_COUNT = 4;
    localparam int MPR_W     = 8;
    localparam int DQ_LANES  = 8;
    localparam int BURST_UI  = 8;

    localparam int SEL_W   = $clog2(MPR_COUNT);
    localparam int BURST_W = DQ_LANES * BURST_UI;

    typedef enum logic [1:0] {
        FMT_SERIAL   = 2'b00,
        FMT_PARALLEL = 2'b01,
        FMT_STAGGER  = 2'b10,
        FMT_RSVD     = 2'b11
    } rd_fmt_e;

    typedef logic [MPR_W-1:0] pat_t;

    typedef struct packed {
        logic               valid;
        logic [BURST_W-1:0] data;
    } burst_t;

    // Register idx < log2(width) alternates in runs of 2^idx, high runs first
    // from the LSB side; the remaining registers reset to zero.
    function automatic pat_t reset_pattern(input int idx);
        pat_t p;
        for (int b = 0; b < MPR_W; b++) begin
            if (idx < $clog2(MPR_W))
                p[b] = (((b >> idx) & 1) == 0);
            else
                p[b] = 1'b0;
        end
        return p;
    endfunction

    // The reserved code falls back to serial.
    function automatic rd_fmt_e norm_fmt(input logic [1:0] code);
        case (code)
            2'b01:   return FMT_PARALLEL;
            2'b10:   return FMT_STAGGER;
            default: return FMT_SERIAL;
        endcase
    endfunction

endpackage

// File: rtl/mpr_regfile.sv
module mpr_regfile
    import mpr_train_pkg::*;
#(
    parameter int NUM = MPR_COUNT,
    parameter int W   = MPR_W,
    localparam int SW = $clog2(NUM)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   active_i,
    input  logic                   wr_i,
    input  logic [SW-1:0]          wr_sel_i,
    input  logic [W-1:0]           wr_data_i,
    output logic [NUM-1:0][W-1:0]  regs_o
);

    logic [NUM-1:0][W-1:0] regs_q;

    for (genvar r = 0; r < NUM; r++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs_q[r] <= W'(reset_pattern(r));
            else if (active_i && wr_i && (wr_sel_i == SW'(r)))
                regs_q[r] <= wr_data_i;
        end
    end

    assign regs_o = regs_q;

    AST_WRITE_GATED: assert property (@(posedge clk) disable iff (rst)
        !(active_i && wr_i) |=> $stable(regs_q)); // R4

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        (active_i && wr_i) |=> (regs_q[$past(wr_sel_i)] == $past(wr_data_i))); // R3

endmodule

// File: rtl/mpr_mode_ctl.sv
module mpr_mode_ctl
    import mpr_train_pkg::*;
#(
    parameter int NUM = MPR_COUNT,
    localparam int SW = $clog2(NUM)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pre_all_i,
    input  logic          mode_cmd_i,
    input  logic          mode_on_i,
    input  logic [1:0]    mode_fmt_i,
    input  logic          stag_rd_i,
    output logic          active_o,
    output rd_fmt_e       fmt_o,
    output logic [SW-1:0] group_o
);

    logic          armed_q;
    logic          active_q;
    rd_fmt_e       fmt_q;
    logic [SW-1:0] group_q;

    // A precharge-all arms the path; the next mode command consumes it.
    always_ff @(posedge clk) begin
        if (rst)
            armed_q <= 1'b0;
        else if (pre_all_i)
            armed_q <= 1'b1;
        else if (mode_cmd_i)
            armed_q <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            fmt_q    <= FMT_SERIAL;
        end else if (mode_cmd_i) begin
            fmt_q <= norm_fmt(mode_fmt_i);
            if (!mode_on_i)
                active_q <= 1'b0;
            else if (armed_q)
                active_q <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || mode_cmd_i)
            group_q <= '0;
        else if (stag_rd_i)
            group_q <= (group_q == SW'(NUM - 1)) ? '0 : group_q + 1'b1;
    end

    assign active_o = active_q;
    assign fmt_o    = fmt_q;
    assign group_o  = group_q;

    AST_ENABLE_NEEDS_ARM: assert property (@(posedge clk) disable iff (rst)
        $rose(active_q) |-> $past(mode_cmd_i && mode_on_i && armed_q)); // R2

    AST_DISABLE_WINS: assert property (@(posedge clk) disable iff (rst)
        (mode_cmd_i && !mode_on_i) |=> !active_q); // R2

    AST_GROUP_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(mode_cmd_i || stag_rd_i) |=> $stable(group_q)); // R8

    AST_GROUP_CLEAR: assert property (@(posedge clk) disable iff (rst)
        mode_cmd_i |=> (group_q == '0)); // R8

endmodule

// File: rtl/mpr_burst_gen.sv
module mpr_burst_gen
    import mpr_train_pkg::*;
#(
    parameter int NUM   = MPR_COUNT,
    parameter int W     = MPR_W,
    parameter int LANES = DQ_LANES,
    parameter int UIS   = BURST_UI,
    localparam int SW   = $clog2(NUM),
    localparam int BW   = LANES * UIS
) (
    input  logic [NUM-1:0][W-1:0] regs_i,
    input  rd_fmt_e               fmt_i,
    input  logic [SW-1:0]         sel_i,
    input  logic [SW-1:0]         group_i,
    output logic [BW-1:0]         burst_o
);

    // Register feeding each lane in staggered form.
    logic [LANES-1:0][SW-1:0] stag_idx;

    for (genvar i = 0; i < LANES; i++) begin : g_lane_idx
        localparam int SLOT = i % NUM;
        logic [SW:0] sum;
        always_comb begin
            sum = (SW+1)'(SLOT) + {1'b0, group_i};
            if (sum >= (SW+1)'(NUM))
                stag_idx[i] = SW'(sum - (SW+1)'(NUM));
            else
                stag_idx[i] = SW'(sum);
        end
    end

    for (genvar n = 0; n < UIS; n++) begin : g_ui
        localparam int SER_BIT = W - 1 - (n % W);
        for (genvar i = 0; i < LANES; i++) begin : g_bit
            localparam int PAR_BIT = i % W;
            always_comb begin
                case (fmt_i)
                    FMT_PARALLEL: burst_o[n*LANES + i] = regs_i[sel_i][PAR_BIT];
                    FMT_STAGGER:  burst_o[n*LANES + i] = regs_i[stag_idx[i]][SER_BIT];
                    default:      burst_o[n*LANES + i] = regs_i[sel_i][SER_BIT];
                endcase
            end
        end
    end

endmodule

// File: rtl/mpr_train_readout.sv
module mpr_train_readout
    import mpr_train_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               pre_all_i,
    input  logic               mode_cmd_i,
    input  logic               mode_on_i,
    input  logic [1:0]         mode_fmt_i,
    input  logic               wr_i,
    input  logic [SEL_W-1:0]   wr_sel_i,
    input  logic [MPR_W-1:0]   wr_data_i,
    input  logic               rd_i,
    input  logic [SEL_W-1:0]   rd_sel_i,
    output logic               mpr_active_o,
    output logic               burst_valid_o,
    output logic [BURST_W-1:0] burst_o
);

    logic [MPR_COUNT-1:0][MPR_W-1:0] regs;
    logic                            active;
    rd_fmt_e                         fmt;
    logic [SEL_W-1:0]                group;
    logic [BURST_W-1:0]              burst_next;
    logic                            rd_take;
    burst_t                          out_q;

    assign rd_take = rd_i && active;

    mpr_mode_ctl #(.NUM(MPR_COUNT)) u_mode (
        .clk        (clk),
        .rst        (rst),
        .pre_all_i  (pre_all_i),
        .mode_cmd_i (mode_cmd_i),
        .mode_on_i  (mode_on_i),
        .mode_fmt_i (mode_fmt_i),
        .stag_rd_i  (rd_take && (fmt == FMT_STAGGER)),
        .active_o   (active),
        .fmt_o      (fmt),
        .group_o    (group)
    );

    mpr_regfile #(.NUM(MPR_COUNT), .W(MPR_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .active_i  (active),
        .wr_i      (wr_i),
        .wr_sel_i  (wr_sel_i),
        .wr_data_i (wr_data_i),
        .regs_o    (regs)
    );

    mpr_burst_gen #(
        .NUM   (MPR_COUNT),
        .W     (MPR_W),
        .LANES (DQ_LANES),
        .UIS   (BURST_UI)
    ) u_gen (
        .regs_i  (regs),
        .fmt_i   (fmt),
        .sel_i   (rd_sel_i),
        .group_i (group),
        .burst_o (burst_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q.valid <= rd_take;
            out_q.data  <= rd_take ? burst_next : '0;
        end
    end

    assign mpr_active_o  = active;
    assign burst_valid_o = out_q.valid;
    assign burst_o       = out_q.data;

    AST_NO_BURST_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        (rd_i && !mpr_active_o) |=> (!burst_valid_o && (burst_o == '0))); // R4

    AST_VALID_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
        burst_valid_o |-> $past(rd_i && mpr_active_o)); // R10

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !burst_valid_o |-> (burst_o == '0)); // R10

    AST_READ_GIVES_VALID: assert property (@(posedge clk) disable iff (rst)
        (rd_i && mpr_active_o) |=> burst_valid_o); // R10

endmodule

// File: tb/mpr_train_readout_tb.sv
`timescale 1ns/1ps
module mpr_train_readout_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        pre_all_i, mode_cmd_i, mode_on_i;
    logic [1:0]  mode_fmt_i;
    logic        wr_i, rd_i;
    logic [1:0]  wr_sel_i, rd_sel_i;
    logic [7:0]  wr_data_i;
    logic        mpr_active_o, burst_valid_o;
    logic [63:0] burst_o;

    always #10 clk = ~clk;

    mpr_train_readout dut_i (
        .clk(clk), .rst(rst),
        .pre_all_i(pre_all_i), .mode_cmd_i(mode_cmd_i),
        .mode_on_i(mode_on_i), .mode_fmt_i(mode_fmt_i),
        .wr_i(wr_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
        .rd_i(rd_i), .rd_sel_i(rd_sel_i),
        .mpr_active_o(mpr_active_o), .burst_valid_o(burst_valid_o),
        .burst_o(burst_o)
    );

    int tests  = 0;
    int errors = 0;

    // Bench-side model state
    logic [3:0][7:0] sh;
    logic            m_active, m_armed;
    int              m_fmt, m_raw_fmt, m_k;

    typedef struct packed {
        logic [1:0] op;   // 0 write, 1 read, 2 precharge-all + enabling mode command
        logic [1:0] sel;
        logic [7:0] data; // write value, or readout form code for op 2
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{2'd2, 2'd0, 8'h01},   // parallel
        '{2'd1, 2'd0, 8'h00},
        '{2'd1, 2'd2, 8'h00},
        '{2'd0, 2'd1, 8'hA5},
        '{2'd1, 2'd1, 8'h00},   // write then read next cycle (R3)
        '{2'd2, 2'd0, 8'h02},   // staggered
        '{2'd1, 2'd3, 8'h00},
        '{2'd1, 2'd0, 8'h00},
        '{2'd1, 2'd1, 8'h00},
        '{2'd1, 2'd2, 8'h00},
        '{2'd1, 2'd0, 8'h00},   // fifth read, after wrap
        '{2'd0, 2'd3, 8'h3C},
        '{2'd1, 2'd0, 8'h00},
        '{2'd2, 2'd0, 8'h03},   // reserved code
        '{2'd1, 2'd3, 8'h00},
        '{2'd1, 2'd1, 8'h00},
        '{2'd2, 2'd0, 8'h02},   // staggered again: rotation restarts
        '{2'd1, 2'd2, 8'h00},
        '{2'd2, 2'd0, 8'h00},   // serial
        '{2'd0, 2'd0, 8'h81}
    };

    function automatic logic [63:0] model_burst(input logic [3:0][7:0] r,
                                                input int f, input int s, input int g);
        logic [63:0] e;
        for (int n = 0; n < 8; n++) begin
            for (int i = 0; i < 8; i++) begin
                case (f)
                    1:       e[n*8+i] = r[s][i];
                    2:       e[n*8+i] = r[((i % 4) + g) % 4][7-n];
                    default: e[n*8+i] = r[s][7-n];
                endcase
            end
        end
        return e;
    endfunction

    function automatic string fmt_tag(input int raw);
        case (raw)
            1:       return "R6";
            2:       return "R7 R8";
            3:       return "R9";
            default: return "R5";
        endcase
    endfunction

    task automatic check64(input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic clear_inputs();
        pre_all_i = 0; mode_cmd_i = 0; mode_on_i = 0; mode_fmt_i = 0;
        wr_i = 0; wr_sel_i = 0; wr_data_i = 0; rd_i = 0; rd_sel_i = 0;
    endtask

    task automatic do_pre_all();
        @(negedge clk); pre_all_i = 1;
        @(negedge clk); clear_inputs();
        m_armed = 1;
    endtask

    task automatic do_mode(input logic on, input int f);
        @(negedge clk); mode_cmd_i = 1; mode_on_i = on; mode_fmt_i = 2'(f);
        @(negedge clk); clear_inputs();
        if (!on) m_active = 0;
        else if (m_armed) m_active = 1;
        m_armed   = 0;
        m_raw_fmt = f;
        m_fmt     = (f == 3) ? 0 : f;
        m_k       = 0;
    endtask

    task automatic do_write(input int s, input logic [7:0] d);
        @(negedge clk); wr_i = 1; wr_sel_i = 2'(s); wr_data_i = d;
        @(negedge clk); clear_inputs();
        if (m_active) sh[s] = d;
    endtask

    task automatic do_read(input int s, input string tag);
        logic [63:0] exp;
        @(negedge clk); rd_i = 1; rd_sel_i = 2'(s);
        exp = m_active ? model_burst(sh, m_fmt, s, m_k) : 64'd0;
        @(negedge clk);
        clear_inputs();
        check64({tag, " valid"}, {63'd0, burst_valid_o}, {63'd0, m_active});
        check64({tag, " burst"}, burst_o, exp);
        if (m_active && m_fmt == 2) m_k = (m_k + 1) % 4;
    endtask

    initial begin
        clear_inputs();
        sh = {8'h00, 8'h0F, 8'h33, 8'h55};
        m_active = 0; m_armed = 0; m_fmt = 0; m_raw_fmt = 0; m_k = 0;
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;

        // R1: reset state at the ports
        check64("R1 active after reset", {63'd0, mpr_active_o}, 64'd0);
        check64("R1 valid after reset", {63'd0, burst_valid_o}, 64'd0);
        check64("R1 burst after reset", burst_o, 64'd0);

        // R4: closed path ignores reads and writes
        do_read(0, "R4 read while off");
        do_write(0, 8'hAA);

        // R2: enabling without a precharge-all has no effect
        do_mode(1'b1, 0);
        check64("R2 no arm no enable", {63'd0, mpr_active_o}, 64'd0);
        do_read(1, "R2 R4 read after unarmed enable");

        // R2: precharge-all then enable
        do_pre_all();
        do_mode(1'b1, 0);
        check64("R2 armed enable", {63'd0, mpr_active_o}, 64'd1);

        // R1 reset patterns, R4 write while off did not land
        do_read(0, "R4 R1 reg0 untouched");
        do_read(1, "R1 R5 reg1");
        do_read(2, "R1 R5 reg2");
        do_read(3, "R1 R5 reg3");

        // R10: valid lasts a single cycle
        @(negedge clk);
        check64("R10 valid one cycle", {63'd0, burst_valid_o}, 64'd0);
        check64("R10 idle burst zero", burst_o, 64'd0);

        // Vector walk
        for (int v = 0; v < NV; v++) begin
            case (VECS[v].op)
                2'd0: do_write(int'(VECS[v].sel), VECS[v].data);
                2'd1: do_read(int'(VECS[v].sel), fmt_tag(m_raw_fmt));
                2'd2: begin
                    do_pre_all();
                    do_mode(1'b1, int'(VECS[v].data[1:0]));
                end
                default: ;
            endcase
        end
        do_read(0, "R3 R5 serial after write");

        // R8: rotation index restarts on a mode command
        do_pre_all();
        do_mode(1'b1, 2);
        do_read(3, "R8 stagger k0 a");
        do_read(3, "R8 stagger k1");
        do_pre_all();
        do_mode(1'b1, 2);
        do_read(3, "R8 stagger restart k0");

        // R2: disable closes the path, R4 then gates reads and writes
        do_mode(1'b0, 0);
        check64("R2 disable", {63'd0, mpr_active_o}, 64'd0);
        do_write(2, 8'hFF);
        do_read(2, "R4 read after disable");
        do_pre_all();
        do_mode(1'b1, 0);
        do_read(2, "R4 reg2 kept after gated write");

        $display("  [TB] %0d tests run, %0d failed", tests, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, errors);
        $finish;
    end

endmodule